// File: doc/BRIEF.md
# Two-Port Storage Adapter Control and Interrupt Registers

This block is the register-mapped control and interrupt front end of a storage host adapter with two serial ports. Software reaches it over a plain 32-bit register bus with separate write and read strobes and a registered read return. It holds a global control word, a sticky per-port interrupt summary, and, for each port, a control word, an interrupt status word and an interrupt enable word. Control and enable bits are never written directly. Each one is raised through a set alias and dropped through a clear alias, so that software never needs a read-modify-write.

Each port engine reports events as single-cycle pulses on a 12-bit vector, and these pulses latch into the port's status word. A port raises its interrupt when any enabled status bit is set. That interrupt goes to one of four legacy lines, picked by a 2-bit steering field kept in the port's enable word. It also feeds the global summary, and the summary drives a message-interrupt request. After one request, no further request is made until software acknowledges it.

The completion status bit has two clear policies, chosen by a per-port control bit. It can be cleared as a side effect of reading the status word, or it can be cleared only by an explicit write of one.

Top module: `storage_csr`

## Requirements
- R1: After reset the global control word reads 0x8100_0000, the global summary reads 0, and `msiReq` is low.
- R2: While global control bit 31 is 1, both `portReset` outputs are high and every port word is held at zero. Port writes made in that state have no effect. Writing the bit to 1 again clears all port words.
- R3: In global control, only bit 31 and bits 1:0 (the per-port enables) store written data. Bit 24 always reads 1, and all other bits, including bit 30, read 0.
- R4: Port p's control word uses byte addresses 0x1000+p*0x2000 (set alias) and +0x4 (clear alias), and both aliases read back the word. The defined bits are 0 (drives `portReset`), 1 (drives `devReset`), 3 (keeps completion from clearing on read) and 13 (drives `pmEnable`). The output follows the bit from the cycle after the write.
- R5: Port p's enable word uses byte addresses base+0x10 (set alias) and base+0x14 (clear alias). Enable bits 11 and 7:0 are set or cleared by a written one. A write to the set alias also loads bits 31:30 (steering) directly; the clear alias leaves steering unchanged. The word reads as {steer, 0…, enables}.
- R6: Status at base+0x8 holds bits 11 and 7:0. A one on the matching `portEvent` bit sets a status bit, and writing one to it clears it. Event bits 10:8 are discarded.
- R7: If an event and a write-one clear reach the same status bit in the same cycle, the bit is set afterwards.
- R8: When control bit 3 is 0, a read of the status word returns its value and clears bit 0 (completion) in that same cycle, leaving the other bits. When control bit 3 is 1, reads clear nothing.
- R9: Port p raises `intLine[steer]` (0 to 3) while any bit of status AND enable is set and global enable bit p is 1.
- R10: Global summary bit p (address 0x0044) becomes 1 one cycle after port p's gated interrupt is active and then stays set. Writing one clears it, but it sets again at once if the source is still active.
- R11: `msiReq` is a one-cycle pulse raised when any summary bit is set and a request is permitted. Only one request is made until a write of 1 to global control bit 30 (address 0x0040) permits the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 16 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after `busRdEn` |
| portEvent | input | 24 | Event pulses, 12 bits per port, port 0 in bits 11:0 |
| portReset | output | 2 | Per-port engine reset |
| devReset | output | 2 | Per-port attached-device reset request |
| pmEnable | output | 2 | Per-port multiplier support enable |
| intLine | output | 4 | Legacy interrupt lines A to D |
| msiReq | output | 1 | Message-interrupt request pulse |

## Verification
There are two same-cycle collisions on a status bit: an event pulse with a bus write-one clear, and an event pulse with a clearing status read. The bench makes the first happen by driving the event vector and the status write on the same falling edge, once for a bit that is already set and once for a bit that is clear. It then expects both bits to read back as one. For the read-clear policy, the bench reads status twice in a row under each setting of control bit 3. It expects the completion bit, and only that bit, to vanish between the two reads only when bit 3 is zero.

// File: rtl/storage_csr_pkg.sv
package storage_csr_pkg;

  localparam int NUM_PORTS = 2;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int EVT_W     = 12;
  localparam int NUM_LINES = 4;
  localparam int STEER_W   = $clog2(NUM_LINES);
  localparam int PIW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  localparam int GCTRL_ADDR  = 'h0040;
  localparam int GSTAT_ADDR  = 'h0044;
  localparam int PORT_BASE   = 'h1000;
  localparam int PORT_STRIDE = 'h2000;

  localparam int OFS_CTRL_SET = 'h00;
  localparam int OFS_CTRL_CLR = 'h04;
  localparam int OFS_STAT     = 'h08;
  localparam int OFS_EN_SET   = 'h10;
  localparam int OFS_EN_CLR   = 'h14;

  localparam int GC_RST = 31;
  localparam int GC_ACK = 30;
  localparam int GC_CAP = 24;

  localparam int PC_PRST  = 0;
  localparam int PC_DRST  = 1;
  localparam int PC_NOCLR = 3;
  localparam int PC_PM    = 13;
  localparam int INT_DONE = 0;
  localparam int STEER_LSB = DATA_W - STEER_W;

  localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << PC_PRST) | (DATA_W'(1) << PC_DRST) |
                                            (DATA_W'(1) << PC_NOCLR) | (DATA_W'(1) << PC_PM);
  localparam logic [DATA_W-1:0] INT_MASK  = DATA_W'(32'h0000_08FF);

  typedef enum logic [2:0] {
    RD_NONE, RD_GCTRL, RD_GSTAT, RD_CTRL, RD_STAT, RD_EN
  } rd_sel_e;

  typedef struct packed {
    logic                 gCtrlWr;
    logic                 gStatWr;
    logic [NUM_PORTS-1:0] ctrlSetWr;
    logic [NUM_PORTS-1:0] ctrlClrWr;
    logic [NUM_PORTS-1:0] statWr;
    logic [NUM_PORTS-1:0] enSetWr;
    logic [NUM_PORTS-1:0] enClrWr;
    logic [NUM_PORTS-1:0] statRd;
    rd_sel_e              rdSel;
    logic [PIW-1:0]       rdPort;
  } csr_strobe_t;

  function automatic logic [ADDR_W-1:0] portAddr(input int p, input int ofs);
    return ADDR_W'(PORT_BASE + p * PORT_STRIDE + ofs);
  endfunction

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import storage_csr_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output csr_strobe_t       strb
);

  always_comb begin
    strb = '0;
    if (busAddr == ADDR_W'(GCTRL_ADDR)) begin
      strb.gCtrlWr = busWrEn;
      if (busRdEn) strb.rdSel = RD_GCTRL;
    end
    if (busAddr == ADDR_W'(GSTAT_ADDR)) begin
      strb.gStatWr = busWrEn;
      if (busRdEn) strb.rdSel = RD_GSTAT;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (busAddr == portAddr(p, OFS_CTRL_SET)) begin
        strb.ctrlSetWr[p] = busWrEn;
        if (busRdEn) begin strb.rdSel = RD_CTRL; strb.rdPort = PIW'(p); end
      end
      if (busAddr == portAddr(p, OFS_CTRL_CLR)) begin
        strb.ctrlClrWr[p] = busWrEn;
        if (busRdEn) begin strb.rdSel = RD_CTRL; strb.rdPort = PIW'(p); end
      end
      if (busAddr == portAddr(p, OFS_STAT)) begin
        strb.statWr[p] = busWrEn;
        strb.statRd[p] = busRdEn;
        if (busRdEn) begin strb.rdSel = RD_STAT; strb.rdPort = PIW'(p); end
      end
      if (busAddr == portAddr(p, OFS_EN_SET)) begin
        strb.enSetWr[p] = busWrEn;
        if (busRdEn) begin strb.rdSel = RD_EN; strb.rdPort = PIW'(p); end
      end
      if (busAddr == portAddr(p, OFS_EN_CLR)) begin
        strb.enClrWr[p] = busWrEn;
        if (busRdEn) begin strb.rdSel = RD_EN; strb.rdPort = PIW'(p); end
      end
    end
  end

endmodule

// File: rtl/csr_port.sv
module csr_port
  import storage_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               portClr,
  input  logic               ctrlSetWr,
  input  logic               ctrlClrWr,
  input  logic               statWr,
  input  logic               enSetWr,
  input  logic               enClrWr,
  input  logic               statRd,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [EVT_W-1:0]   evt,
  output logic [DATA_W-1:0]  ctrlQ,
  output logic [DATA_W-1:0]  statQ,
  output logic [DATA_W-1:0]  enQ,
  output logic               irq,
  output logic [STEER_W-1:0] steer
);

  logic [DATA_W-1:0]  ctrlR, ctrlN;
  logic [DATA_W-1:0]  statR, statN;
  logic [DATA_W-1:0]  enR, enN;
  logic [STEER_W-1:0] steerR, steerN;

  always_comb begin
    ctrlN = ctrlR;
    if (ctrlSetWr) ctrlN = ctrlN | (wdata & CTRL_MASK);
    if (ctrlClrWr) ctrlN = ctrlN & ~(wdata & CTRL_MASK);

    enN = enR;
    if (enSetWr) enN = enN | (wdata & INT_MASK);
    if (enClrWr) enN = enN & ~(wdata & INT_MASK);
    steerN = enSetWr ? wdata[STEER_LSB +: STEER_W] : steerR;

    // clears first, event last so an event always wins
    statN = statR;
    if (statWr) statN = statN & ~(wdata & INT_MASK);
    if (statRd && !ctrlR[PC_NOCLR]) statN[INT_DONE] = 1'b0;
    statN = statN | (DATA_W'(evt) & INT_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR  <= '0;
      statR  <= '0;
      enR    <= '0;
      steerR <= '0;
    end else if (portClr) begin
      ctrlR  <= '0;
      statR  <= '0;
      enR    <= '0;
      steerR <= '0;
    end else begin
      ctrlR  <= ctrlN;
      statR  <= statN;
      enR    <= enN;
      steerR <= steerN;
    end
  end

  always_comb begin
    enQ = enR;
    enQ[STEER_LSB +: STEER_W] = steerR;
  end

  assign ctrlQ = ctrlR;
  assign statQ = statR;
  assign irq   = |(statR & enR);
  assign steer = steerR;

endmodule

// File: rtl/csr_dp.sv
module csr_dp
  import storage_csr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  csr_strobe_t                strb,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_PORTS*EVT_W-1:0] evtFlat,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_PORTS-1:0]       portReset,
  output logic [NUM_PORTS-1:0]       devReset,
  output logic [NUM_PORTS-1:0]       pmEnable,
  output logic [NUM_LINES-1:0]       intLine,
  output logic                       msiReq
);

  logic                 gRst;
  logic [NUM_PORTS-1:0] gEn;
  logic [NUM_PORTS-1:0] gStat, gStatN;
  logic                 msiArmed, msiReqR;
  logic [DATA_W-1:0]    rdataR, rdN;
  logic [NUM_PORTS-1:0] portIrq;
  logic                 ackWr;

  logic [DATA_W-1:0]  ctrlQ [NUM_PORTS];
  logic [DATA_W-1:0]  statQ [NUM_PORTS];
  logic [DATA_W-1:0]  enQ   [NUM_PORTS];
  logic [STEER_W-1:0] steer [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    csr_port u_port (
      .clk       (clk),
      .rstN      (rstN),
      .portClr   (gRst),
      .ctrlSetWr (strb.ctrlSetWr[p]),
      .ctrlClrWr (strb.ctrlClrWr[p]),
      .statWr    (strb.statWr[p]),
      .enSetWr   (strb.enSetWr[p]),
      .enClrWr   (strb.enClrWr[p]),
      .statRd    (strb.statRd[p]),
      .wdata     (wdata),
      .evt       (evtFlat[p*EVT_W +: EVT_W]),
      .ctrlQ     (ctrlQ[p]),
      .statQ     (statQ[p]),
      .enQ       (enQ[p]),
      .irq       (portIrq[p]),
      .steer     (steer[p])
    );
    assign portReset[p] = gRst | ctrlQ[p][PC_PRST];
    assign devReset[p]  = ctrlQ[p][PC_DRST];
    assign pmEnable[p]  = ctrlQ[p][PC_PM];
  end

  assign ackWr = strb.gCtrlWr & wdata[GC_ACK];

  always_comb begin
    gStatN = gStat;
    if (strb.gStatWr) gStatN = gStatN & ~wdata[NUM_PORTS-1:0];
    gStatN = gStatN | (portIrq & gEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gRst     <= 1'b1;
      gEn      <= '0;
      gStat    <= '0;
      msiArmed <= 1'b1;
      msiReqR  <= 1'b0;
    end else begin
      if (strb.gCtrlWr) begin
        gRst <= wdata[GC_RST];
        gEn  <= wdata[NUM_PORTS-1:0];
      end
      gStat    <= gStatN;
      msiReqR  <= msiArmed & (|gStat);
      msiArmed <= ackWr | (msiArmed & ~(|gStat));
    end
  end

  always_comb begin
    intLine = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (portIrq[p] && gEn[p] && (steer[p] == STEER_W'(k))) intLine[k] = 1'b1;
      end
    end
  end

  always_comb begin
    rdN = '0;
    unique case (strb.rdSel)
      RD_GCTRL: begin
        rdN[GC_RST]         = gRst;
        rdN[GC_CAP]         = 1'b1;
        rdN[NUM_PORTS-1:0]  = gEn;
      end
      RD_GSTAT: rdN[NUM_PORTS-1:0] = gStat;
      RD_CTRL:  rdN = ctrlQ[strb.rdPort];
      RD_STAT:  rdN = statQ[strb.rdPort];
      RD_EN:    rdN = enQ[strb.rdPort];
      default:  rdN = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataR <= '0;
    else if (strb.rdSel != RD_NONE) rdataR <= rdN;
  end

  assign rdata  = rdataR;
  assign msiReq = msiReqR;

endmodule

// File: rtl/storage_csr.sv
module storage_csr
  import storage_csr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic [NUM_PORTS*EVT_W-1:0] portEvent,
  output logic [NUM_PORTS-1:0]       portReset,
  output logic [NUM_PORTS-1:0]       devReset,
  output logic [NUM_PORTS-1:0]       pmEnable,
  output logic [NUM_LINES-1:0]       intLine,
  output logic                       msiReq
);

  csr_strobe_t strb;

  csr_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  csr_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .evtFlat   (portEvent),
    .rdata     (busRdata),
    .portReset (portReset),
    .devReset  (devReset),
    .pmEnable  (pmEnable),
    .intLine   (intLine),
    .msiReq    (msiReq)
  );

endmodule

// File: rtl/storage_csr_chk.sv
module storage_csr_chk
  import storage_csr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [NUM_PORTS-1:0] portReset,
  input logic [NUM_PORTS-1:0] pmEnable,
  input logic                 msiReq
);

  logic gRstSeen;
  logic gWr, ackNow, pmSetWr, pmClrWr;

  assign gWr     = busWrEn && (busAddr == ADDR_W'(GCTRL_ADDR));
  assign ackNow  = gWr && busWdata[GC_ACK];
  assign pmSetWr = busWrEn && (busAddr == portAddr(0, OFS_CTRL_SET)) && busWdata[PC_PM];
  assign pmClrWr = busWrEn && (busAddr == portAddr(0, OFS_CTRL_CLR)) && busWdata[PC_PM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gRstSeen <= 1'b1;
    else if (gWr) gRstSeen <= busWdata[GC_RST];
  end

  assert_rst_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (gWr && busWdata[GC_RST]) |=> (&portReset));

  assert_pm_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pmSetWr && !gRstSeen) |=> pmEnable[0]);

  assert_pm_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    pmClrWr |=> !pmEnable[0]);

  assert_msi_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (msiReq && !$past(ackNow)) |=> !msiReq);

endmodule

bind storage_csr storage_csr_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .portReset (portReset),
  .pmEnable  (pmEnable),
  .msiReq    (msiReq)
);

// File: tb/sim_storage_csr.sv
`timescale 1ns/1ps
module sim_storage_csr;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] portEvent = '0;
  logic [1:0]  portReset, devReset, pmEnable;
  logic [3:0]  intLine;
  logic        msiReq;

  int checks = 0;
  int failures = 0;
  int msiCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  storage_csr u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .portEvent(portEvent), .portReset(portReset), .devReset(devReset),
    .pmEnable(pmEnable), .intLine(intLine), .msiReq(msiReq)
  );

  always @(negedge clk) if (rstN && msiReq) msiCount++;

  function automatic logic [15:0] pa(input int p, input int ofs);
    return 16'('h1000 + p * 'h2000 + ofs);
  endfunction

  function automatic logic [31:0] enView(input logic [1:0] st, input logic [31:0] en);
    return {st, 30'b0} | (en & 32'h0000_08FF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); busRdEn = 1'b1; busAddr = a;
    @(negedge clk); busRdEn = 1'b0; d = busRdata;
  endtask

  task automatic pulse(input int p, input logic [11:0] e);
    @(negedge clk); portEvent[p*12 +: 12] = e;
    @(negedge clk); portEvent = '0;
  endtask

  task automatic collide(input int p, input logic [11:0] e, input logic [31:0] d);
    @(negedge clk); portEvent[p*12 +: 12] = e;
    busWrEn = 1'b1; busAddr = pa(p, 'h08); busWdata = d;
    @(negedge clk); portEvent = '0; busWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ctrlM [2];
    logic [31:0] enM [2];
    logic [1:0]  stM [2];
    void'($urandom(32'd20240611));

    idle(2);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(16'h0040, v); chk("R1 gctrl reset", v, 32'h8100_0000);
    rd(16'h0044, v); chk("R1 gstat reset", v, 32'h0);
    chk("R1 msiReq low", {31'b0, msiReq}, 32'h0);
    chk("R2 portReset during global reset", {30'b0, portReset}, 32'h3);

    // R2 writes ignored while held
    wr(pa(0, 'h00), 32'h0000_2000);
    rd(pa(0, 'h00), v); chk("R2 ctrl write ignored", v, 32'h0);
    chk("R2 pmEnable stays low", {30'b0, pmEnable}, 32'h0);

    // R3 writable bits
    wr(16'h0040, 32'h0000_0003);
    rd(16'h0040, v); chk("R3 gctrl readback", v, 32'h0100_0003);
    chk("R2 portReset released", {30'b0, portReset}, 32'h0);
    wr(16'h0040, 32'h7E00_00FC);
    rd(16'h0040, v); chk("R3 reserved and ack read zero", v, 32'h0100_0000);
    wr(16'h0040, 32'h0000_0003);

    // R4 R5 random set/clear aliases
    for (int p = 0; p < 2; p++) begin ctrlM[p] = '0; enM[p] = '0; stM[p] = '0; end
    for (int i = 0; i < 60; i++) begin
      int p;
      int op;
      logic [31:0] d;
      p  = $urandom_range(0, 1);
      op = $urandom_range(0, 3);
      d  = $urandom;
      case (op)
        0: begin wr(pa(p, 'h00), d); ctrlM[p] = ctrlM[p] | (d & 32'h200B); end
        1: begin wr(pa(p, 'h04), d); ctrlM[p] = ctrlM[p] & ~(d & 32'h200B); end
        2: begin wr(pa(p, 'h10), d); enM[p] = enM[p] | (d & 32'h08FF); stM[p] = d[31:30]; end
        default: begin wr(pa(p, 'h14), d); enM[p] = enM[p] & ~(d & 32'h08FF); end
      endcase
      if (op < 2) begin
        rd(pa(p, ($urandom_range(0, 1) != 0) ? 'h04 : 'h00), v);
        chk("R4 ctrl alias readback", v, ctrlM[p]);
        chk("R4 ctrl outputs", {29'b0, pmEnable[p], devReset[p], portReset[p]},
            {29'b0, ctrlM[p][13], ctrlM[p][1], ctrlM[p][0]});
      end else begin
        rd(pa(p, ($urandom_range(0, 1) != 0) ? 'h14 : 'h10), v);
        chk("R5 enable alias readback", v, enView(stM[p], enM[p]));
      end
    end
    wr(pa(1, 'h14), 32'hFFFF_FFFF);
    rd(pa(1, 'h10), v); chk("R5 clear alias keeps steering", v, enView(stM[1], 32'h0));
    for (int p = 0; p < 2; p++) begin
      wr(pa(p, 'h04), 32'hFFFF_FFFF);
      wr(pa(p, 'h14), 32'hFFFF_FFFF);
    end

    // R6 R8 R9 R10 R11 port 0 events, no-clear-on-read
    wr(pa(0, 'h00), 32'h0000_0008);
    wr(pa(0, 'h10), 32'h8000_08FF);
    pulse(0, 12'hF05);
    rd(pa(0, 'h08), v); chk("R6 event latch, bits 10:8 dropped", v, 32'h0000_0805);
    rd(pa(0, 'h08), v); chk("R8 no clear on read when bit3 set", v, 32'h0000_0805);
    chk("R9 steer to line 2", {28'b0, intLine}, 32'h4);
    rd(16'h0044, v); chk("R10 summary port0", v, 32'h1);
    chk("R11 one request", msiCount, 1);
    pulse(0, 12'h002);
    idle(4);
    chk("R11 no request before ack", msiCount, 1);

    wr(pa(0, 'h08), 32'h0000_0004);
    rd(pa(0, 'h08), v); chk("R6 write one clears", v, 32'h0000_0803);

    // R7 collisions
    collide(0, 12'h800, 32'h0000_0800);
    rd(pa(0, 'h08), v); chk("R7 event beats clear on set bit", v, 32'h0000_0803);
    collide(0, 12'h004, 32'h0000_0004);
    rd(pa(0, 'h08), v); chk("R7 event beats clear on clear bit", v, 32'h0000_0807);

    // R8 read clears completion only
    wr(pa(0, 'h04), 32'h0000_0008);
    rd(pa(0, 'h08), v); chk("R8 read returns value", v, 32'h0000_0807);
    rd(pa(0, 'h08), v); chk("R8 completion cleared by read", v, 32'h0000_0806);

    // R10 sticky while source active
    wr(16'h0044, 32'h1);
    rd(16'h0044, v); chk("R10 resets while source active", v, 32'h1);
    wr(pa(0, 'h08), 32'hFFFF_FFFF);
    rd(pa(0, 'h08), v); chk("R6 clear all", v, 32'h0);
    chk("R9 line drops", {28'b0, intLine}, 32'h0);
    rd(16'h0044, v); chk("R10 stays set after source gone", v, 32'h1);
    wr(16'h0044, 32'h1);
    rd(16'h0044, v); chk("R10 write one clears", v, 32'h0);

    // R9 global enable gating, port 1 steering
    wr(16'h0040, 32'h0000_0002);
    pulse(0, 12'h002);
    idle(1);
    chk("R9 gated by global enable", {28'b0, intLine}, 32'h0);
    rd(16'h0044, v); chk("R10 gated summary", v, 32'h0);
    wr(pa(1, 'h10), 32'hC000_0020);
    pulse(1, 12'h020);
    chk("R9 port1 steer to line 3", {28'b0, intLine}, 32'h8);
    rd(16'h0044, v); chk("R10 summary port1", v, 32'h2);
    idle(3);
    chk("R11 still waiting for ack", msiCount, 1);
    wr(16'h0040, 32'h4000_0002);
    idle(4);
    chk("R11 ack permits next request", msiCount, 2);

    // R2 global reset clears ports
    wr(16'h0040, 32'h8000_0000);
    idle(1);
    rd(pa(1, 'h10), v); chk("R2 enable cleared", v, 32'h0);
    rd(pa(0, 'h08), v); chk("R2 status cleared", v, 32'h0);
    chk("R2 portReset asserted", {30'b0, portReset}, 32'h3);
    chk("R2 lines idle", {28'b0, intLine}, 32'h0);
    rd(16'h0040, v); chk("R3 gctrl in reset", v, 32'h8100_0000);

    summary();
  end

endmodule